// File: doc/BRIEF.md
# Snooping Cache-Line Coherence Controller

This block holds the coherence state and address tag of a single cache block shared between a local CPU and a snooping bus. The CPU presents read or write requests carrying a tag. The controller compares that tag with the stored one and decides whether the access hits. On a miss, or on a write to a read-only copy, it issues the bus transactions needed to gain the block. If the line it is about to replace is owned, it writes that line back first.

On the bus side, the controller watches read-miss and write-miss transactions from other processors. When one of them names the tag this line holds, it reacts. An owned copy is written back and memory is told to abort its own reply. The line is then downgraded to read-only or invalidated, depending on the kind of miss.

The data array, the bus arbiter and memory sit outside the block. All bus outputs are registered, one-cycle pulses that appear in the cycle after the clock edge that sampled the request.

States (internal): ST_INV (Invalid), ST_SHR (Shared, read-only), ST_EXC (Exclusive, read/write), ST_PEND_RD and ST_PEND_WR (a CPU miss whose write-back has gone out and whose miss request is due in the next cycle). Transitions:
- CPU read or write from ST_INV.
- CPU read hit, read miss or write from ST_SHR.
- CPU hit, read miss or write miss from ST_EXC.
- Pending completion to ST_SHR or ST_EXC.
- Snooped write-miss invalidate from ST_SHR or ST_EXC.
- Snooped read-miss downgrade from ST_EXC.

Top module: `snoop_line_ctrl`

## Requirements
- R1: After reset, line_state reads 0 (Invalid) and every bus and hit output is low.
- R2: From Invalid, a CPU read gives a bus_rd_miss pulse with miss_tag equal to the request tag, and line_state becomes 1 (Shared). A CPU write gives a bus_wr_miss pulse and line_state becomes 2 (Exclusive). Both pulses appear in the cycle after the sampling edge.
- R3: In Shared, a read with a matching tag pulses cpu_hit and causes no bus activity. A read with a different tag pulses bus_rd_miss with the new tag, and the line stays Shared holding that tag.
- R4: In Shared, any CPU write, with a matching tag or not, pulses bus_wr_miss with the request tag and moves the line to Exclusive.
- R5: In Exclusive, reads and writes with a matching tag pulse cpu_hit and cause no bus activity.
- R6: In Exclusive, a read with a different tag pulses bus_wb with wb_tag equal to the old tag, and mem_abort stays low. In the next cycle it pulses bus_rd_miss with the new tag, and the line ends in Shared. During the gap, line_state reads 3 (in transit).
- R7: In Exclusive, a write with a different tag pulses bus_wb with the old tag. In the next cycle it pulses bus_wr_miss with the new tag, and the line ends in Exclusive.
- R8: A snooped write miss (snp_wr=1) whose tag matches moves Shared to Invalid with no output. In Exclusive it also pulses bus_wb and mem_abort with the held tag and goes to Invalid.
- R9: A snooped read miss (snp_wr=0) whose tag matches moves Exclusive to Shared with bus_wb and mem_abort pulses. In Shared it changes nothing and raises no output.
- R10: A snoop whose tag differs from the held tag, or that arrives while the line is Invalid, changes nothing and raises no output.
- R11: When a snoop and a CPU request are sampled at the same edge, the snoop takes effect first, and the CPU request is judged against the state the snoop left.
- R12: CPU requests and snoops sampled while line_state is 3 are ignored. The line still completes its pending miss in that cycle.
- R13: bus_rd_miss and bus_wr_miss are never high together, and the in-transit state never lasts more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU request valid |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_tag | input | TAG_W | Tag of the CPU access |
| snp_valid | input | 1 | Snooped bus transaction valid |
| snp_wr | input | 1 | 1 = snooped write miss, 0 = snooped read miss |
| snp_tag | input | TAG_W | Tag of the snooped transaction |
| cpu_hit | output | 1 | Pulse: CPU access completed without bus action |
| bus_rd_miss | output | 1 | Pulse: place a read miss on the bus |
| bus_wr_miss | output | 1 | Pulse: place a write miss on the bus |
| miss_tag | output | TAG_W | Tag carried by the miss pulse |
| bus_wb | output | 1 | Pulse: write the held block back |
| wb_tag | output | TAG_W | Tag of the block being written back |
| mem_abort | output | 1 | Pulse: memory must abort its response |
| line_state | output | 2 | 0 Invalid, 1 Shared, 2 Exclusive, 3 in transit |

## Verification
The hardest situation to reach is a snoop and a CPU request landing at the same edge while the line is owned. In that case the snoop's forced write-back and the CPU's resulting hit or miss must both appear in one cycle. The directed sequence sets the line to Exclusive on a known tag. It then applies a matching snooped read together with a CPU read, and a matching snooped write together with a CPU write. A further case presents a new request and a snoop exactly in the in-transit cycle. A long stretch of random traffic over a tag set of four values then keeps producing these collisions, and the behavioural model is compared against the outputs on every clock.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

    typedef enum logic [2:0] {
        ST_INV     = 3'd0,
        ST_SHR     = 3'd1,
        ST_EXC     = 3'd2,
        ST_PEND_RD = 3'd3,
        ST_PEND_WR = 3'd4
    } line_st_e;

    localparam logic [1:0] VIS_INV  = 2'd0;
    localparam logic [1:0] VIS_SHR  = 2'd1;
    localparam logic [1:0] VIS_EXC  = 2'd2;
    localparam logic [1:0] VIS_PEND = 2'd3;

    function automatic logic [1:0] visible_state(line_st_e s);
        logic [1:0] v;
        unique case (s)
            ST_INV:                 v = VIS_INV;
            ST_SHR:                 v = VIS_SHR;
            ST_EXC:                 v = VIS_EXC;
            ST_PEND_RD, ST_PEND_WR: v = VIS_PEND;
            default:                v = VIS_INV;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/snoop_bus_side.sv
module snoop_bus_side
    import snoop_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  line_st_e           cur_state,
    input  logic [TAG_W-1:0]   held_tag,
    input  logic               snp_valid,
    input  logic               snp_wr,
    input  logic [TAG_W-1:0]   snp_tag,
    output line_st_e           mid_state,
    output logic               snp_wb,
    output logic               snp_abort
);

    logic tag_same;
    logic hit_line;

    assign tag_same = (snp_tag == held_tag);
    assign hit_line = snp_valid && tag_same;

    always_comb begin
        mid_state = cur_state;
        snp_wb    = 1'b0;
        snp_abort = 1'b0;
        unique case (cur_state)
            ST_SHR: begin
                if (hit_line && snp_wr) begin
                    mid_state = ST_INV;
                end
            end
            ST_EXC: begin
                if (hit_line) begin
                    snp_wb    = 1'b1;
                    snp_abort = 1'b1;
                    mid_state = snp_wr ? ST_INV : ST_SHR;
                end
            end
            ST_INV, ST_PEND_RD, ST_PEND_WR: begin
                mid_state = cur_state;
            end
            default: mid_state = cur_state;
        endcase
    end

endmodule

// File: rtl/snoop_cpu_side.sv
module snoop_cpu_side
    import snoop_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  line_st_e           mid_state,
    input  logic [TAG_W-1:0]   held_tag,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [TAG_W-1:0]   cpu_tag,
    output line_st_e           nxt_state,
    output logic [TAG_W-1:0]   nxt_tag,
    output logic               hit,
    output logic               rd_miss,
    output logic               wr_miss,
    output logic               cpu_wb,
    output logic [TAG_W-1:0]   req_tag
);

    logic tag_same;
    assign tag_same = (cpu_tag == held_tag);

    always_comb begin
        nxt_state = mid_state;
        nxt_tag   = held_tag;
        hit       = 1'b0;
        rd_miss   = 1'b0;
        wr_miss   = 1'b0;
        cpu_wb    = 1'b0;
        req_tag   = '0;
        unique case (mid_state)
            ST_PEND_RD: begin
                rd_miss   = 1'b1;
                req_tag   = held_tag;
                nxt_state = ST_SHR;
            end
            ST_PEND_WR: begin
                wr_miss   = 1'b1;
                req_tag   = held_tag;
                nxt_state = ST_EXC;
            end
            ST_INV: begin
                if (cpu_req) begin
                    req_tag   = cpu_tag;
                    nxt_tag   = cpu_tag;
                    rd_miss   = !cpu_we;
                    wr_miss   = cpu_we;
                    nxt_state = cpu_we ? ST_EXC : ST_SHR;
                end
            end
            ST_SHR: begin
                if (cpu_req) begin
                    if (!cpu_we && tag_same) begin
                        hit = 1'b1;
                    end else begin
                        req_tag   = cpu_tag;
                        nxt_tag   = cpu_tag;
                        rd_miss   = !cpu_we;
                        wr_miss   = cpu_we;
                        nxt_state = cpu_we ? ST_EXC : ST_SHR;
                    end
                end
            end
            ST_EXC: begin
                if (cpu_req) begin
                    if (tag_same) begin
                        hit = 1'b1;
                    end else begin
                        cpu_wb    = 1'b1;
                        nxt_tag   = cpu_tag;
                        nxt_state = cpu_we ? ST_PEND_WR : ST_PEND_RD;
                    end
                end
            end
            default: nxt_state = ST_INV;
        endcase
    end

endmodule

// File: rtl/snoop_line_ctrl.sv
module snoop_line_ctrl
    import snoop_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [TAG_W-1:0]   cpu_tag,
    input  logic               snp_valid,
    input  logic               snp_wr,
    input  logic [TAG_W-1:0]   snp_tag,
    output logic               cpu_hit,
    output logic               bus_rd_miss,
    output logic               bus_wr_miss,
    output logic [TAG_W-1:0]   miss_tag,
    output logic               bus_wb,
    output logic [TAG_W-1:0]   wb_tag,
    output logic               mem_abort,
    output logic [1:0]         line_state
);

    line_st_e           state_q;
    line_st_e           mid_state;
    line_st_e           nxt_state;
    logic [TAG_W-1:0]   tag_q;
    logic [TAG_W-1:0]   nxt_tag;
    logic               snp_wb;
    logic               snp_abort;
    logic               c_hit;
    logic               c_rd;
    logic               c_wr;
    logic               c_wb;
    logic [TAG_W-1:0]   c_tag;

    snoop_bus_side #(.TAG_W(TAG_W)) u_bus (
        .cur_state (state_q),
        .held_tag  (tag_q),
        .snp_valid (snp_valid),
        .snp_wr    (snp_wr),
        .snp_tag   (snp_tag),
        .mid_state (mid_state),
        .snp_wb    (snp_wb),
        .snp_abort (snp_abort)
    );

    snoop_cpu_side #(.TAG_W(TAG_W)) u_cpu (
        .mid_state (mid_state),
        .held_tag  (tag_q),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_tag   (cpu_tag),
        .nxt_state (nxt_state),
        .nxt_tag   (nxt_tag),
        .hit       (c_hit),
        .rd_miss   (c_rd),
        .wr_miss   (c_wr),
        .cpu_wb    (c_wb),
        .req_tag   (c_tag)
    );

    // State and tag register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INV;
            tag_q   <= '0;
        end else begin
            state_q <= nxt_state;
            tag_q   <= nxt_tag;
        end
    end

    // Registered output pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_hit     <= 1'b0;
            bus_rd_miss <= 1'b0;
            bus_wr_miss <= 1'b0;
            miss_tag    <= '0;
            bus_wb      <= 1'b0;
            wb_tag      <= '0;
            mem_abort   <= 1'b0;
        end else begin
            cpu_hit     <= c_hit;
            bus_rd_miss <= c_rd;
            bus_wr_miss <= c_wr;
            miss_tag    <= c_tag;
            bus_wb      <= snp_wb | c_wb;
            wb_tag      <= (snp_wb | c_wb) ? tag_q : '0;
            mem_abort   <= snp_abort;
        end
    end

    assign line_state = visible_state(state_q);

    // A CPU-driven write-back is followed by its miss request.
    assert_wb_then_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wb && !mem_abort) |=> (bus_rd_miss || bus_wr_miss));

    // R13: never both miss kinds at once.
    assert_single_miss_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd_miss && bus_wr_miss));

    // R13: transit state lasts at most one cycle.
    assert_short_transit_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == VIS_PEND) |=> (line_state != VIS_PEND));

    // A write miss always leaves the line owned.
    assert_wrmiss_owns_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_miss |-> (line_state == VIS_EXC));

    // An abort only follows a snoop that hit an owned line.
    assert_abort_from_owned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_abort |-> ($past(line_state) == VIS_EXC));

    // A hit is never accompanied by a miss request.
    assert_hit_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit |-> (!bus_rd_miss && !bus_wr_miss));

endmodule

// File: tb/tb_snoop_line_ctrl.sv
module tb_snoop_line_ctrl;

    localparam int TAG_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cpu_req = 1'b0;
    logic             cpu_we = 1'b0;
    logic [TAG_W-1:0] cpu_tag = '0;
    logic             snp_valid = 1'b0;
    logic             snp_wr = 1'b0;
    logic [TAG_W-1:0] snp_tag = '0;
    logic             cpu_hit, bus_rd_miss, bus_wr_miss, bus_wb, mem_abort;
    logic [TAG_W-1:0] miss_tag, wb_tag;
    logic [1:0]       line_state;

    always #2 clk = ~clk;

    snoop_line_ctrl #(.TAG_W(TAG_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_tag(cpu_tag),
        .snp_valid(snp_valid), .snp_wr(snp_wr), .snp_tag(snp_tag),
        .cpu_hit(cpu_hit), .bus_rd_miss(bus_rd_miss), .bus_wr_miss(bus_wr_miss),
        .miss_tag(miss_tag), .bus_wb(bus_wb), .wb_tag(wb_tag),
        .mem_abort(mem_abort), .line_state(line_state)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // Behavioural reference: 0 I, 1 S, 2 E, 3 transit
    int m_st = 0;
    int m_tag = 0;
    bit m_pw = 0;
    bit e_hit, e_rd, e_wr, e_wb, e_ab;
    int e_mt, e_wt;

    task automatic model_step();
        bit hitm;
        e_hit = 0; e_rd = 0; e_wr = 0; e_wb = 0; e_ab = 0; e_mt = 0; e_wt = 0;
        if (m_st == 3) begin
            e_mt = m_tag;
            if (m_pw) begin e_wr = 1; m_st = 2; end
            else      begin e_rd = 1; m_st = 1; end
        end else begin
            if (snp_valid && m_st != 0 && int'(snp_tag) == m_tag) begin
                if (m_st == 2) begin
                    e_wb = 1; e_ab = 1; e_wt = m_tag;
                    m_st = snp_wr ? 0 : 1;
                end else if (snp_wr) begin
                    m_st = 0;
                end
            end
            if (cpu_req) begin
                hitm = (m_st != 0) && (int'(cpu_tag) == m_tag);
                if (m_st == 0 || (m_st == 1 && !(hitm && !cpu_we))) begin
                    e_rd = !cpu_we; e_wr = cpu_we; e_mt = cpu_tag;
                    m_tag = cpu_tag; m_st = cpu_we ? 2 : 1;
                end else if (hitm) begin
                    e_hit = 1;
                end else begin
                    e_wb = 1; e_wt = m_tag;
                    m_tag = cpu_tag; m_pw = cpu_we; m_st = 3;
                end
            end
        end
    endtask

    task automatic compare(string rq);
        bit bad;
        vectors++;
        bad = (cpu_hit !== e_hit) || (bus_rd_miss !== e_rd) || (bus_wr_miss !== e_wr) ||
              (bus_wb !== e_wb) || (mem_abort !== e_ab) || (line_state !== 2'(m_st)) ||
              ((e_rd || e_wr) && int'(miss_tag) != e_mt) || (e_wb && int'(wb_tag) != e_wt);
        if (bad) begin
            miscompares++;
            $display("FAIL %s: got hit=%0b rd=%0b wr=%0b mt=%0h wb=%0b wt=%0h ab=%0b st=%0d ; exp hit=%0b rd=%0b wr=%0b mt=%0h wb=%0b wt=%0h ab=%0b st=%0d",
                     rq, cpu_hit, bus_rd_miss, bus_wr_miss, miss_tag, bus_wb, wb_tag, mem_abort, line_state,
                     e_hit, e_rd, e_wr, e_mt, e_wb, e_wt, e_ab, m_st);
        end
    endtask

    // Drive at negedge, let the edge sample, compare at the following negedge.
    task automatic apply(bit rq, bit we, int ct, bit sv, bit sw, int st, string tagname);
        cpu_req = rq; cpu_we = we; cpu_tag = TAG_W'(ct);
        snp_valid = sv; snp_wr = sw; snp_tag = TAG_W'(st);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tagname);
    endtask

    task automatic idle(string tagname);
        apply(0, 0, 0, 0, 0, 0, tagname);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        e_hit = 0; e_rd = 0; e_wr = 0; e_wb = 0; e_ab = 0;
        compare("R1");
        idle("R1");

        apply(1, 0, 'h11, 0, 0, 0, "R2 read from Invalid");
        apply(1, 0, 'h11, 0, 0, 0, "R3 read hit Shared");
        apply(1, 0, 'h22, 0, 0, 0, "R3 read miss Shared");
        apply(1, 1, 'h22, 0, 0, 0, "R4 write hit Shared");
        apply(1, 0, 'h22, 0, 0, 0, "R5 read hit Exclusive");
        apply(1, 1, 'h22, 0, 0, 0, "R5 write hit Exclusive");
        apply(1, 0, 'h33, 0, 0, 0, "R6 read miss Exclusive wb");
        apply(1, 1, 'h44, 1, 1, 'h33, "R12 request and snoop in transit");
        apply(1, 1, 'h55, 0, 0, 0, "R4 write miss Shared");
        apply(1, 1, 'h44, 0, 0, 0, "R7 write miss Exclusive wb");
        idle("R7 write miss issued");
        apply(0, 0, 0, 1, 0, 'h99, "R10 snoop tag mismatch");
        apply(0, 0, 0, 1, 0, 'h44, "R9 snoop read owned");
        apply(0, 0, 0, 1, 0, 'h44, "R9 snoop read Shared");
        apply(0, 0, 0, 1, 1, 'h44, "R8 snoop write Shared");
        apply(0, 0, 0, 1, 1, 'h44, "R10 snoop in Invalid");
        apply(1, 1, 'h66, 0, 0, 0, "R2 write from Invalid");
        apply(0, 0, 0, 1, 1, 'h66, "R8 snoop write owned");
        apply(1, 1, 'h77, 0, 0, 0, "R2 write from Invalid");
        apply(1, 0, 'h77, 1, 0, 'h77, "R11 snoop read plus cpu read");
        apply(1, 1, 'h77, 1, 1, 'h77, "R11 snoop write plus cpu write");
        idle("R13 idle");

        for (int i = 0; i < 3000; i++) begin
            bit rq, we, sv, sw;
            int ct, st;
            rq = ($urandom % 3) != 0;
            we = $urandom % 2;
            sv = ($urandom % 3) == 0;
            sw = $urandom % 2;
            ct = 'hA0 + ($urandom % 4);
            st = 'hA0 + ($urandom % 4);
            apply(rq, we, ct, sv, sw, st, "R11 R13 random traffic");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got running, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule